// File: doc/BRIEF.md
# Flow-Control Pause Frame Generator

This block produces flow-control PAUSE frames on a nibble-wide MII-style transmit port. A host writes a 16-bit pause quantum into a small control register. Setting the start bit in the same write asks the block for one frame. A busy flag rises at once and stays high while the frame is being produced. The host polls the flag and writes the register again only after it reads low. Each frame carries the multicast flow-control destination, a source address taken from an input, the MAC-control type and PAUSE opcode, the pause quantum, zero padding and a CRC-32 frame check sequence. The generator has no link to any receive-side pause timer: a running timer neither blocks it nor is changed by it.

The sequencer is a five-state machine. `ST_IDLE` waits for busy. `ST_PRE` sends sixteen preamble and start-delimiter nibbles. `ST_DATA` sends the sixty header and pad bytes while the CRC accumulates. `ST_FCS` sends eight check nibbles. `ST_GAP` holds the line quiet for the inter-frame gap. The transitions are IDLE→PRE on busy, PRE→DATA after nibble 15, DATA→FCS after nibble 119, FCS→GAP after nibble 7, and GAP→IDLE after the last gap nibble. Busy is cleared on that last transition.

Top module: `pause_frame_tx`

## Requirements
- R1: After reset, busy is 0, tx_en is 0, txd is 0 and the stored pause time is 0.
- R2: A write while idle with the start bit at 0 stores the pause time and starts no frame: busy and tx_en stay 0.
- R3: A write while idle with the start bit at 1 stores the pause time and sets busy on that edge. tx_en rises on the next edge, carrying the first preamble nibble.
- R4: While busy is 1, writes have no effect: the stored pause time keeps its value and no extra frame follows.
- R5: Bytes 0–6 are 0x55 and byte 7 is 0xD5. Bytes 8–13 are 01 80 C2 00 00 01. Bytes 14–19 are the source address, bits 47:40 first. Bytes 20–21 are 0x88 0x08. Bytes 22–23 are 0x00 0x01. Bytes 24–25 hold the pause time, bits 15:8 first.
- R6: Each byte is sent as two nibbles, bits 3:0 first. tx_en stays high without a break for exactly 144 nibbles.
- R7: Bytes 26–67 are zero, so the frame after the delimiter is 60 bytes long before the check sequence.
- R8: Bytes 68–71 are the check sequence. It is the reflected CRC-32 (polynomial 0xEDB88320, initial value 0xFFFFFFFF) taken over bytes 8–67, least-significant bit first, then complemented. Its bits 7:0 are sent first.
- R9: busy stays 1 through the frame and through 24 nibble times after tx_en falls, then clears. txd is 0 whenever tx_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit nibble clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_go | input | 1 | Start bit written with the strobe |
| wr_pause_time | input | 16 | Pause quantum written with the strobe |
| src_mac | input | 48 | Source address placed in frames |
| busy | output | 1 | Frame or gap in progress |
| pause_time | output | 16 | Stored pause quantum (readback) |
| txd | output | 4 | Transmit nibble |
| tx_en | output | 1 | Transmit enable |

## Verification
The bench aims at writes that arrive in the middle of a frame. A register that does not honour busy would change the quantum in the readback, or would send a second frame once the gap ends. It also checks each state boundary: a miscounted preamble, data or check state shows up as a length other than 144 or as bytes in the wrong place. Pause values 0x0000 and 0xFFFF, together with random source addresses, catch byte-order and nibble-order mistakes and any wrong CRC initial value or output complement. Counting the gap catches a busy flag that clears too early, or one that never clears.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_DATA,
        ST_FCS,
        ST_GAP
    } pfg_state_e;

    localparam int PRE_NIBS  = 16;
    localparam int FCS_NIBS  = 8;
    localparam int CRC_W     = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;

    // one octet of the frame body after the start delimiter
    function automatic logic [7:0] body_byte(input int unsigned idx,
                                             input logic [47:0] sa,
                                             input logic [15:0] quanta);
        logic [7:0] b;
        b = 8'h00;
        unique case (idx)
            0:  b = 8'h01;
            1:  b = 8'h80;
            2:  b = 8'hC2;
            3:  b = 8'h00;
            4:  b = 8'h00;
            5:  b = 8'h01;
            6:  b = sa[47:40];
            7:  b = sa[39:32];
            8:  b = sa[31:24];
            9:  b = sa[23:16];
            10: b = sa[15:8];
            11: b = sa[7:0];
            12: b = 8'h88;
            13: b = 8'h08;
            14: b = 8'h00;
            15: b = 8'h01;
            16: b = quanta[15:8];
            17: b = quanta[7:0];
            default: b = 8'h00;
        endcase
        return b;
    endfunction

    // reflected CRC advanced by four data bits, bit 0 first
    function automatic logic [CRC_W-1:0] crc_step4(input logic [CRC_W-1:0] c,
                                                   input logic [3:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = 0; i < 4; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/pfg_ctrl.sv
module pfg_ctrl #(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_go,
    input  logic [TIME_W-1:0] wr_time,
    input  logic              done,
    output logic              busy,
    output logic [TIME_W-1:0] time_q
);

    logic accept;
    assign accept = wr_en && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            time_q <= '0;
        end else if (done) begin
            busy   <= 1'b0;
        end else if (accept) begin
            time_q <= wr_time;
            if (wr_go) busy <= 1'b1;
        end
    end

    assert_busy_locks_time_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(time_q));

    assert_go_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_go && !busy) |=> busy);

endmodule

// File: rtl/pfg_crc.sv
module pfg_crc
    import pfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             en,
    input  logic [3:0]       nib,
    output logic [CRC_W-1:0] crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc <= CRC_SEED;
        else if (init) crc <= CRC_SEED;
        else if (en)   crc <= crc_step4(crc, nib);
    end

endmodule

// File: rtl/pfg_seq.sv
module pfg_seq
    import pfg_pkg::*;
#(
    parameter int TIME_W    = 16,
    parameter int ADDR_W    = 48,
    parameter int BODY_BYTES = 60,
    parameter int GAP_NIBS  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic [ADDR_W-1:0] src_mac,
    input  logic [TIME_W-1:0] quanta,
    input  logic [CRC_W-1:0]  crc,
    output logic              crc_init,
    output logic              crc_en,
    output logic              done,
    output logic [3:0]        txd,
    output logic              tx_en
);

    localparam int BODY_NIBS = 2 * BODY_BYTES;
    localparam int MAX_NIBS  = (BODY_NIBS > GAP_NIBS) ? BODY_NIBS : GAP_NIBS;
    localparam int CNT_W     = $clog2(MAX_NIBS + 1);

    pfg_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       cur_byte;
    logic [CRC_W-1:0] fcs_word;

    // state register and nibble counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (busy) state <= ST_PRE;
                end
                ST_PRE: begin
                    if (cnt == CNT_W'(PRE_NIBS - 1)) begin
                        state <= ST_DATA;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                ST_DATA: begin
                    if (cnt == CNT_W'(BODY_NIBS - 1)) begin
                        state <= ST_FCS;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                ST_FCS: begin
                    if (cnt == CNT_W'(FCS_NIBS - 1)) begin
                        state <= ST_GAP;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                ST_GAP: begin
                    if (cnt == CNT_W'(GAP_NIBS - 1)) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign fcs_word = ~crc;

    // outputs decoded from state and counter
    always_comb begin
        cur_byte = 8'h00;
        txd      = 4'h0;
        tx_en    = 1'b0;
        crc_init = 1'b0;
        crc_en   = 1'b0;
        done     = 1'b0;
        unique case (state)
            ST_IDLE: crc_init = 1'b1;
            ST_PRE: begin
                tx_en    = 1'b1;
                cur_byte = (cnt >= CNT_W'(PRE_NIBS - 2)) ? 8'hD5 : 8'h55;
                txd      = cnt[0] ? cur_byte[7:4] : cur_byte[3:0];
            end
            ST_DATA: begin
                tx_en    = 1'b1;
                crc_en   = 1'b1;
                cur_byte = body_byte(int'(cnt >> 1), src_mac, quanta);
                txd      = cnt[0] ? cur_byte[7:4] : cur_byte[3:0];
            end
            ST_FCS: begin
                tx_en = 1'b1;
                txd   = 4'(fcs_word >> {cnt[2:0], 2'b00});
            end
            ST_GAP: done = (cnt == CNT_W'(GAP_NIBS - 1));
            default: ;
        endcase
    end

    assert_txen_inside_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> busy);

    assert_quiet_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (txd == 4'h0));

    assert_start_next_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> tx_en);

    assert_gap_holds_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> busy);

endmodule

// File: rtl/pause_frame_tx.sv
module pause_frame_tx
    import pfg_pkg::*;
#(
    parameter int TIME_W     = 16,
    parameter int ADDR_W     = 48,
    parameter int BODY_BYTES = 60,
    parameter int GAP_NIBS   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_go,
    input  logic [TIME_W-1:0] wr_pause_time,
    input  logic [ADDR_W-1:0] src_mac,
    output logic              busy,
    output logic [TIME_W-1:0] pause_time,
    output logic [3:0]        txd,
    output logic              tx_en
);

    logic             done;
    logic             crc_init;
    logic             crc_en;
    logic [CRC_W-1:0] crc;

    pfg_ctrl #(.TIME_W(TIME_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_go   (wr_go),
        .wr_time (wr_pause_time),
        .done    (done),
        .busy    (busy),
        .time_q  (pause_time)
    );

    pfg_seq #(
        .TIME_W     (TIME_W),
        .ADDR_W     (ADDR_W),
        .BODY_BYTES (BODY_BYTES),
        .GAP_NIBS   (GAP_NIBS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy     (busy),
        .src_mac  (src_mac),
        .quanta   (pause_time),
        .crc      (crc),
        .crc_init (crc_init),
        .crc_en   (crc_en),
        .done     (done),
        .txd      (txd),
        .tx_en    (tx_en)
    );

    pfg_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .en    (crc_en),
        .nib   (txd),
        .crc   (crc)
    );

endmodule

// File: tb/sim_pause_frame_tx.sv
`timescale 1ns/1ps
module sim_pause_frame_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_go = 1'b0;
    logic [15:0] wr_pause_time = '0;
    logic [47:0] src_mac = '0;
    logic        busy;
    logic [15:0] pause_time;
    logic [3:0]  txd;
    logic        tx_en;

    int total = 0;
    int bad   = 0;
    int ncap  = 0;
    int quiet_err = 0;
    logic [3:0] cap [0:255];
    logic [3:0] exp_n [0:143];

    always #2 clk = ~clk;

    pause_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_go(wr_go),
        .wr_pause_time(wr_pause_time), .src_mac(src_mac),
        .busy(busy), .pause_time(pause_time), .txd(txd), .tx_en(tx_en)
    );

    always @(negedge clk) begin
        if (rst_n && tx_en && ncap < 256) begin
            cap[ncap] = txd;
            ncap++;
        end
        if (rst_n && !tx_en && txd != 4'h0) quiet_err++;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] ref_crc(input logic [7:0] b [0:71]);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int k = 8; k < 68; k++)
            for (int i = 0; i < 8; i++)
                c = ((c[0] ^ b[k][i]) != 0) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        return ~c;
    endfunction

    task automatic build_expected(input logic [15:0] pt, input logic [47:0] sa);
        logic [7:0] b [0:71];
        logic [31:0] f;
        for (int k = 0; k < 72; k++) b[k] = 8'h00;
        for (int k = 0; k < 7; k++) b[k] = 8'h55;
        b[7] = 8'hD5;
        b[8] = 8'h01; b[9] = 8'h80; b[10] = 8'hC2; b[11] = 8'h00; b[12] = 8'h00; b[13] = 8'h01;
        for (int k = 0; k < 6; k++) b[14+k] = sa[47-8*k -: 8];
        b[20] = 8'h88; b[21] = 8'h08; b[22] = 8'h00; b[23] = 8'h01;
        b[24] = pt[15:8]; b[25] = pt[7:0];
        f = ref_crc(b);
        for (int k = 0; k < 4; k++) b[68+k] = f[8*k +: 8];
        for (int k = 0; k < 72; k++) begin
            exp_n[2*k]   = b[k][3:0];
            exp_n[2*k+1] = b[k][7:4];
        end
    endtask

    task automatic cmp_range(input int lo, input int hi, input string req);
        int first = -1;
        for (int k = lo; k <= hi; k++)
            if (first < 0 && cap[k] !== exp_n[k]) first = k;
        if (first < 0) check(1'b1, req, 0, 0);
        else check(1'b0, req, cap[first], exp_n[first]);
    endtask

    task automatic run_frame(input logic [15:0] pt, input logic [47:0] sa);
        int len;
        int gap;
        src_mac = sa;
        build_expected(pt, sa);
        @(negedge clk);
        ncap = 0;
        wr_en = 1'b1; wr_go = 1'b1; wr_pause_time = pt;
        @(negedge clk);
        wr_en = 1'b0; wr_go = 1'b0;
        check(busy === 1'b1 && tx_en === 1'b0 && pause_time === pt, "R3 accept", {busy, tx_en}, 2'b10);
        @(negedge clk);
        check(tx_en === 1'b1, "R3 tx_en next edge", tx_en, 1);
        len = 1;
        do begin
            if (len == 40) begin
                wr_en = 1'b1; wr_go = 1'b1; wr_pause_time = ~pt;
            end else begin
                wr_en = 1'b0; wr_go = 1'b0;
            end
            @(negedge clk);
            if (tx_en) len++;
        end while (tx_en);
        wr_en = 1'b0; wr_go = 1'b0;
        check(len == 144 && ncap == 144, "R6 length", len, 144);
        gap = 0;
        while (busy && gap < 1000) begin
            gap++;
            @(negedge clk);
        end
        check(gap == 24, "R9 gap", gap, 24);
        cmp_range(0, 15, "R5 preamble");
        cmp_range(16, 51, "R5 header R6 nibble order");
        cmp_range(52, 135, "R7 pad");
        cmp_range(136, 143, "R8 fcs");
        check(pause_time === pt, "R4 time kept", pause_time, pt);
        ncap = 0;
        repeat (30) @(negedge clk);
        check(ncap == 0 && busy === 1'b0, "R4 no extra frame", ncap, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && tx_en === 1'b0 && txd === 4'h0 && pause_time === 16'h0,
              "R1 reset", {busy, tx_en, txd}, 0);

        wr_en = 1'b1; wr_go = 1'b0; wr_pause_time = 16'hA5C3;
        @(negedge clk);
        wr_en = 1'b0;
        ncap = 0;
        repeat (20) @(negedge clk);
        check(pause_time === 16'hA5C3 && busy === 1'b0 && ncap == 0, "R2 store only", pause_time, 16'hA5C3);

        run_frame(16'h0000, 48'h0000_0000_0000);
        run_frame(16'hFFFF, 48'hFFFF_FFFF_FFFF);
        run_frame(16'h1234, 48'h0010_A4B5_C6D7);
        for (int n = 0; n < 5; n++)
            run_frame(16'($urandom), {16'($urandom), 32'($urandom)});

        check(quiet_err == 0, "R9 txd zero when idle", quiet_err, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule